// File: doc/BRIEF.md
# Filtered I2C Bus Condition Monitor

This block watches the two raw wires of an I2C bus from inside the peripheral clock domain. Each wire first passes through a two-flop synchronizer and then through a glitch filter. The filter only accepts a new level once the wire has held it for a minimum number of consecutive clocks. That minimum is (3+N) clocks, where N is a 4-bit setting, so it ranges from 3 to 18 clocks.

From the two filtered wires the block recognizes bus START and STOP conditions. It reports each one as a single-cycle pulse. It also keeps a flag that shows whether a transfer is in progress. A clear flag means the bus is idle, with both wires high.

Higher layers use the filtered wires as their clean bus view and use the pulses to frame transfers. When the enable input is low, the block shows an idle bus.

Top module: `i2c_bus_monitor`

## Requirements
- R1: While reset is held and in the first cycle after it, both filtered lines are 1, `start_o` and `stop_o` are 0 and `busy_o` is 0.
- R2: With the block enabled, suppose a raw line changes to a new level and holds it. The filtered copy takes the new level on the (W+2)-th rising edge that samples the new raw level, where W = 3 + `nf_sel_i`. Two of those edges are the synchronizer and W are the filter.
- R3: If a raw line holds a new level for fewer than W consecutive sampling edges and then returns, the filtered line does not change.
- R4: Any sample that goes back to the current filtered level restarts the count. Two short excursions separated by one sample at the old level therefore do not add up.
- R5: With `nf_sel_i`=0 a 2-clock pulse is rejected and a 3-clock pulse passes. With `nf_sel_i`=15 a 17-clock pulse is rejected and an 18-clock pulse passes.
- R6: A START is a filtered SDA fall while filtered SCL is 1 both in the current and the previous cycle. It raises `start_o` for exactly one cycle, on the edge after filtered SDA falls.
- R7: A STOP is a filtered SDA rise under the same SCL condition. It raises `stop_o` for exactly one cycle, on the edge after filtered SDA rises.
- R8: `busy_o` becomes 1 on the same edge that `start_o` becomes 1. It then stays 1 until a STOP or a disable.
- R9: `busy_o` becomes 0 on the same edge that `stop_o` becomes 1.
- R10: While `en_i` is 0, both filtered lines are 1, no pulses occur, `busy_o` is 0 and the filter counts are cleared. After `en_i` returns to 1, a raw line that is already settled at 0 reaches its filtered output on the W-th edge that samples `en_i`=1.
- R11: SDA transitions while filtered SCL is 0 produce no pulse and leave `busy_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Monitor enable |
| nf_sel_i | input | 4 | Filter setting N; rejection width is 3+N clocks |
| scl_raw_i | input | 1 | Raw clock wire |
| sda_raw_i | input | 1 | Raw data wire |
| scl_f_o | output | 1 | Filtered clock wire |
| sda_f_o | output | 1 | Filtered data wire |
| start_o | output | 1 | One-cycle START pulse |
| stop_o | output | 1 | One-cycle STOP pulse |
| busy_o | output | 1 | Bus-busy flag |

## Verification
Directed pulses exactly one clock shorter than the width and exactly equal to it, at N=0 and N=15, pin down the acceptance threshold. A pulse that is off by one in the comparison is rejected or accepted on the wrong side. A bounce pattern, in which two sub-width excursions are split by a single sample at the old level, separates a count that restarts from one that merely pauses. Fall and rise latencies are measured edge by edge, and so are the pulse and flag timing that follow them. SDA toggling while SCL is low tells real bus conditions apart from plain data edges.

Long runs of random hold lengths, width changes and enable drops are compared cycle by cycle with a bench model built from the requirements. These runs expose errors that only appear when several of these effects interact.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    // Bit order of the two-wire bundle; the filter generate loop indexes by it.
    localparam int LINE_COUNT = 2;
    localparam int IDX_SDA    = 0;
    localparam int IDX_SCL    = 1;

    typedef struct packed {
        logic scl;
        logic sda;
    } wire_pair_t;

    typedef struct packed {
        logic start;
        logic stop;
    } bus_event_t;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_BUSY = 1'b1
    } bus_state_t;

    localparam wire_pair_t PAIR_IDLE = '{scl: 1'b1, sda: 1'b1};

    // Count limit for a given setting: the line flips on the W-th
    // differing sample, i.e. when the counter has reached W-1.
    function automatic int unsigned accept_limit(input int unsigned base,
                                                 input int unsigned sel);
        return base + sel - 1;
    endfunction

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
    parameter int         WIDTH     = 2,
    parameter int         STAGES    = 2,
    parameter logic [0:0] RESET_LVL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) begin
                stage_q[k] <= {WIDTH{RESET_LVL}};
            end
        end else begin
            stage_q[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/i2cmon_glitch_filter.sv
module i2cmon_glitch_filter #(
    parameter int SEL_BITS = 4,
    parameter int BASE_W   = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [SEL_BITS-1:0] sel,
    input  logic                d,
    output logic                q
);

    localparam int MAX_W = BASE_W + (1 << SEL_BITS) - 1;
    localparam int CNT_W = $clog2(MAX_W + 1);

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = CNT_W'(i2cmon_pkg::accept_limit(BASE_W, int'(sel)));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            q     <= 1'b1;
            run_q <= '0;
        end else if (d == q) begin
            // sample agrees with the current level: any run is broken
            run_q <= '0;
        end else if (run_q >= limit) begin
            q     <= d;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

endmodule

// File: rtl/i2cmon_cond_detect.sv
module i2cmon_cond_detect
    import i2cmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  wire_pair_t line,
    output bus_event_t evt,
    output bus_state_t state
);

    wire_pair_t line_d;
    logic       scl_steady;
    bus_event_t evt_next;

    always_comb begin
        scl_steady     = line.scl && line_d.scl;
        evt_next.start = en && scl_steady && line_d.sda && !line.sda;
        evt_next.stop  = en && scl_steady && !line_d.sda && line.sda;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            line_d <= PAIR_IDLE;
            evt    <= '0;
            state  <= BUS_IDLE;
        end else begin
            line_d <= line;
            evt    <= evt_next;
            if (evt_next.start) begin
                state <= BUS_BUSY;
            end else if (evt_next.stop) begin
                state <= BUS_IDLE;
            end
        end
    end

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
    import i2cmon_pkg::*;
#(
    parameter int SEL_BITS    = 4,
    parameter int BASE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_i,
    input  logic [SEL_BITS-1:0] nf_sel_i,
    input  logic                scl_raw_i,
    input  logic                sda_raw_i,
    output logic                scl_f_o,
    output logic                sda_f_o,
    output logic                start_o,
    output logic                stop_o,
    output logic                busy_o
);

    wire_pair_t raw_pair;
    wire_pair_t sync_pair;
    wire_pair_t filt_pair;
    bus_event_t evt;
    bus_state_t state;

    logic [LINE_COUNT-1:0] sync_bits;
    logic [LINE_COUNT-1:0] filt_bits;

    assign raw_pair.scl = scl_raw_i;
    assign raw_pair.sda = sda_raw_i;

    i2cmon_sync #(
        .WIDTH    (LINE_COUNT),
        .STAGES   (SYNC_STAGES),
        .RESET_LVL(1'b1)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_pair),
        .q  (sync_bits)
    );

    assign sync_pair = wire_pair_t'(sync_bits);

    for (genvar i = 0; i < LINE_COUNT; i++) begin : g_line
        i2cmon_glitch_filter #(
            .SEL_BITS(SEL_BITS),
            .BASE_W  (BASE_W)
        ) u_filt (
            .clk(clk),
            .rst(rst),
            .en (en_i),
            .sel(nf_sel_i),
            .d  (sync_bits[i]),
            .q  (filt_bits[i])
        );
    end

    assign filt_pair = wire_pair_t'(filt_bits);

    i2cmon_cond_detect u_cond (
        .clk  (clk),
        .rst  (rst),
        .en   (en_i),
        .line (filt_pair),
        .evt  (evt),
        .state(state)
    );

    assign scl_f_o = filt_pair.scl;
    assign sda_f_o = filt_pair.sda;
    assign start_o = evt.start;
    assign stop_o  = evt.stop;
    assign busy_o  = (state == BUS_BUSY);

endmodule

// File: rtl/i2cmon_chk.sv
module i2cmon_chk (
    input logic clk,
    input logic rst,
    input logic en_i,
    input logic scl_f_o,
    input logic sda_f_o,
    input logic start_o,
    input logic stop_o,
    input logic busy_o
);

    // R6
    single_event_chk: assert property (@(posedge clk) disable iff (rst)
        !(start_o && stop_o));

    // R6
    start_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

    // R7
    stop_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        stop_o |=> !stop_o);

    // R6
    start_sda_low_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |-> !sda_f_o);

    // R7
    stop_sda_high_chk: assert property (@(posedge clk) disable iff (rst)
        stop_o |-> sda_f_o);

    // R8
    busy_with_start_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |-> busy_o);

    // R8
    busy_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> start_o);

    // R9
    busy_clear_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        stop_o |-> !busy_o);

    // R9
    busy_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (stop_o || !$past(en_i)));

    // R10
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (scl_f_o && sda_f_o && !busy_o && !start_o && !stop_o));

    // R3
    sda_min_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && (sda_f_o != $past(sda_f_o))) |=> ($stable(sda_f_o) || !$past(en_i)));

endmodule

bind i2c_bus_monitor i2cmon_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_i),
    .scl_f_o(scl_f_o),
    .sda_f_o(sda_f_o),
    .start_o(start_o),
    .stop_o (stop_o),
    .busy_o (busy_o)
);

// File: tb/i2c_bus_monitor_bench.sv
module i2c_bus_monitor_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic [3:0] nf = 4'd0;
    logic       scl_raw = 1'b1;
    logic       sda_raw = 1'b1;
    logic       scl_f, sda_f, start_p, stop_p, busy;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    i2c_bus_monitor u_i2c_bus_monitor (
        .clk      (clk),
        .rst      (rst),
        .en_i     (en),
        .nf_sel_i (nf),
        .scl_raw_i(scl_raw),
        .sda_raw_i(sda_raw),
        .scl_f_o  (scl_f),
        .sda_f_o  (sda_f),
        .start_o  (start_p),
        .stop_o   (stop_p),
        .busy_o   (busy)
    );

    function automatic int width_of(input logic [3:0] n);
        return 3 + int'(n);
    endfunction

    // requirement model of one filtered line (R2, R3, R4, R10)
    function automatic void line_step(input logic cur, input logic smp, input int cnt,
                                      input int w, input logic on,
                                      output logic nxt, output int ncnt);
        nxt  = cur;
        ncnt = cnt;
        if (!on) begin
            nxt  = 1'b1;
            ncnt = 0;
        end else if (smp == cur) begin
            ncnt = 0;
        end else if (cnt >= w - 1) begin
            nxt  = smp;
            ncnt = 0;
        end else begin
            ncnt = cnt + 1;
        end
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // bench model, updated on the same edges as the design
    logic [1:0] m_s1, m_s2;
    logic m_scl, m_sda, m_pscl, m_psda, m_start, m_stop, m_busy;
    int   m_cscl, m_csda;
    logic n_scl, n_sda;
    int   nc_scl, nc_sda;
    logic ev_start, ev_stop;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 2'b11; m_s2 <= 2'b11;
            m_scl <= 1'b1; m_sda <= 1'b1; m_cscl <= 0; m_csda <= 0;
            m_pscl <= 1'b1; m_psda <= 1'b1;
            m_start <= 1'b0; m_stop <= 1'b0; m_busy <= 1'b0;
        end else begin
            m_s1 <= {scl_raw, sda_raw};
            m_s2 <= m_s1;
            line_step(m_scl, m_s2[1], m_cscl, width_of(nf), en, n_scl, nc_scl);
            line_step(m_sda, m_s2[0], m_csda, width_of(nf), en, n_sda, nc_sda);
            m_scl <= n_scl; m_cscl <= nc_scl;
            m_sda <= n_sda; m_csda <= nc_sda;
            ev_start = en && m_scl && m_pscl && m_psda && !m_sda;
            ev_stop  = en && m_scl && m_pscl && !m_psda && m_sda;
            m_pscl  <= en ? m_scl : 1'b1;
            m_psda  <= en ? m_sda : 1'b1;
            m_start <= ev_start;
            m_stop  <= ev_stop;
            if (!en)           m_busy <= 1'b0;
            else if (ev_start) m_busy <= 1'b1;
            else if (ev_stop)  m_busy <= 1'b0;
        end
    end

    bit cmp_on = 1'b0;
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            check(scl_f == m_scl, "R2", "scl_f vs model", scl_f, m_scl);
            check(sda_f == m_sda, "R2", "sda_f vs model", sda_f, m_sda);
            check(start_p == m_start, "R6", "start vs model", start_p, m_start);
            check(stop_p == m_stop, "R7", "stop vs model", stop_p, m_stop);
            check(busy == m_busy, "R8", "busy vs model", busy, m_busy);
        end
    end

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // fall then rise of SDA with SCL high: latency, pulses, busy (R2 R6 R7 R8 R9)
    task automatic start_stop_seq(input logic [3:0] n);
        int lat;
        nf = n;
        scl_raw = 1'b1; sda_raw = 1'b1;
        settle(25);
        sda_raw = 1'b0;
        lat = 0;
        for (int j = 1; j <= 40; j++) begin
            @(negedge clk);
            if (!sda_f) begin lat = j; break; end
        end
        check(lat == width_of(n) + 2, "R2", "fall latency", lat, width_of(n) + 2);
        check(!start_p, "R6", "start before edge", start_p, 0);
        @(negedge clk);
        check(start_p, "R6", "start pulse", start_p, 1);
        check(busy, "R8", "busy with start", busy, 1);
        @(negedge clk);
        check(!start_p, "R6", "start width", start_p, 0);
        check(busy, "R8", "busy held", busy, 1);
        settle(5);
        sda_raw = 1'b1;
        lat = 0;
        for (int j = 1; j <= 40; j++) begin
            @(negedge clk);
            if (sda_f) begin lat = j; break; end
        end
        check(lat == width_of(n) + 2, "R2", "rise latency", lat, width_of(n) + 2);
        check(busy, "R9", "busy before stop", busy, 1);
        @(negedge clk);
        check(stop_p, "R7", "stop pulse", stop_p, 1);
        check(!busy, "R9", "busy cleared", busy, 0);
        @(negedge clk);
        check(!stop_p, "R7", "stop width", stop_p, 0);
    endtask

    // low pulse of len clocks on one raw line; reports whether the filtered line moved
    task automatic pulse_test(input logic [3:0] n, input bit on_scl, input int len,
                              input bit expect_pass, input string req);
        bit seen;
        nf = n;
        scl_raw = 1'b1; sda_raw = 1'b1;
        settle(25);
        seen = 1'b0;
        if (on_scl) scl_raw = 1'b0; else sda_raw = 1'b0;
        for (int j = 0; j < len; j++) begin
            @(negedge clk);
            if ((on_scl ? scl_f : sda_f) == 1'b0) seen = 1'b1;
        end
        scl_raw = 1'b1; sda_raw = 1'b1;
        for (int j = 0; j < 30; j++) begin
            @(negedge clk);
            if ((on_scl ? scl_f : sda_f) == 1'b0) seen = 1'b1;
        end
        check(seen == expect_pass, req, $sformatf("pulse len %0d N=%0d moved", len, n),
              seen, expect_pass);
    endtask

    initial begin
        int lat;
        bit pulse_seen;
        logic busy_before;
        void'($urandom(32'h1c2b_5eed));
        settle(4);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(scl_f && sda_f, "R1", "filtered after reset", {scl_f, sda_f}, 3);
        check(!start_p && !stop_p, "R1", "pulses after reset", {start_p, stop_p}, 0);
        check(!busy, "R1", "busy after reset", busy, 0);
        cmp_on = 1'b1;

        start_stop_seq(4'd0);
        start_stop_seq(4'd7);
        start_stop_seq(4'd15);

        // R3 sub-width pulses on each line
        pulse_test(4'd5, 1'b0, 7, 1'b0, "R3");
        pulse_test(4'd5, 1'b1, 7, 1'b0, "R3");
        // R5 boundaries
        pulse_test(4'd0, 1'b0, 2, 1'b0, "R5");
        pulse_test(4'd0, 1'b0, 3, 1'b1, "R5");
        pulse_test(4'd15, 1'b0, 17, 1'b0, "R5");
        pulse_test(4'd15, 1'b0, 18, 1'b1, "R5");

        // R4 bounce restarts the count: W=5, low 4, high 1, low 4, then hold low
        nf = 4'd2;
        settle(25);
        pulse_seen = 1'b0;
        sda_raw = 1'b0; repeat (4) begin @(negedge clk); if (!sda_f) pulse_seen = 1'b1; end
        sda_raw = 1'b1; @(negedge clk); if (!sda_f) pulse_seen = 1'b1;
        sda_raw = 1'b0; repeat (4) begin @(negedge clk); if (!sda_f) pulse_seen = 1'b1; end
        sda_raw = 1'b1; repeat (10) begin @(negedge clk); if (!sda_f) pulse_seen = 1'b1; end
        check(!pulse_seen, "R4", "split excursions accepted", pulse_seen, 0);
        sda_raw = 1'b0; repeat (4) @(negedge clk);
        sda_raw = 1'b1; @(negedge clk);
        sda_raw = 1'b0;
        lat = 0;
        for (int j = 1; j <= 40; j++) begin
            @(negedge clk);
            if (!sda_f) begin lat = j; break; end
        end
        check(lat == 7, "R4", "latency after bounce", lat, 7);
        settle(3);

        // R10 disable while busy, then re-enable with SDA settled low
        check(busy, "R10", "busy before disable", busy, 1);
        en = 1'b0;
        @(negedge clk);
        check(sda_f && scl_f, "R10", "filtered while disabled", {scl_f, sda_f}, 3);
        check(!busy, "R10", "busy while disabled", busy, 0);
        settle(6);
        check(!start_p && !stop_p, "R10", "pulses while disabled", {start_p, stop_p}, 0);
        en = 1'b1;
        lat = 0;
        for (int j = 1; j <= 40; j++) begin
            @(negedge clk);
            if (!sda_f) begin lat = j; break; end
        end
        check(lat == width_of(nf), "R10", "latency after enable", lat, width_of(nf));
        sda_raw = 1'b1;
        settle(12);

        // R11 SDA toggles with SCL low
        scl_raw = 1'b0;
        settle(12);
        busy_before = busy;
        pulse_seen = 1'b0;
        for (int k = 0; k < 4; k++) begin
            sda_raw = ~sda_raw;
            repeat (12) begin @(negedge clk); if (start_p || stop_p) pulse_seen = 1'b1; end
        end
        check(!pulse_seen, "R11", "pulse with SCL low", pulse_seen, 0);
        check(busy == busy_before, "R11", "busy with SCL low", busy, busy_before);
        sda_raw = 1'b1; scl_raw = 1'b1;
        settle(30);

        // random hold lengths, widths and enable drops against the model
        for (int seg = 0; seg < 600; seg++) begin
            int hold;
            hold = $urandom_range(1, 22);
            if ($urandom_range(0, 9) == 0) nf = 4'($urandom_range(0, 15));
            en = ($urandom_range(0, 24) != 0);
            if ($urandom_range(0, 1) == 1) scl_raw = ~scl_raw;
            else                           sda_raw = ~sda_raw;
            settle(hold);
        end
        en = 1'b1;
        settle(40);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule